// File: doc/BRIEF.md
# Motor Output Enable Gating

This block sits in front of the six driver pins of a motor power stage. Software writes an 8-bit control byte through a simple write strobe. From three of its bits (output enable, timing enable and direct select), the block decides what each pin drives. The choices are an idle level set per pin, the regular commutation pattern, or a directly written phase word. A per-pin PWM carrier can be gated onto the pins that a mask selects.

The timing-enable bit is a synchronous enable and not a gated clock, so the register stays writable at all times. If timing is switched off while the pins stay enabled, the pins freeze. Pins that were driving a static level keep it. Pins that were carrying PWM settle to a constant, and a mode bit of the control byte picks that constant. The output of every pin is registered.

Top module: `motor_out_gate`

## Requirements
- R1: While reset is asserted the control byte reads 00h and every pin has its output enable low and its data bit 0.
- R2: A byte presented with `wr_en` high is stored whole on that clock edge and appears on `ctrl_out` one cycle later. When `wr_en` is low the byte holds. Bit 7 is output enable, bit 6 is timing enable, bit 4 is direct select and bit 3 is current mode. Bits 5 and 2..0 are only stored.
- R3: With bit 7 at 0, each pin takes its idle state whatever bits 6 and 4 hold. Each pin has a 2-bit idle code: 01 drives 0, 10 drives 1, and 00 or 11 gives high impedance, which means output enable 0 and data 0.
- R4: With bits 7 and 6 at 1 and bit 4 at 0, a pin drives its standard phase bit. Where the standard PWM mask bit is 1, that value is ANDed with the pin's carrier.
- R5: With bits 7, 6 and 4 at 1, a pin drives its direct phase bit, ANDed with the carrier where the direct PWM mask bit is 1.
- R6: With bits 7 and 4 at 1 and bit 6 at 0, a pin drives its direct phase bit as a static level, and the direct PWM mask has no effect.
- R7: With bit 7 at 1 and bits 6 and 4 at 0 (frozen), a pin that was not carrying PWM keeps its data and output-enable values.
- R8: When frozen, a pin that was carrying PWM in the last cycle before the freeze drives 1 if bit 3 is 0 and 0 if bit 3 is 1. A pin counts as carrying PWM when its phase bit and its mask bit were both 1.
- R9: Pin values change on the clock edge after the control byte changes. Phase, mask, carrier and idle inputs sampled on an edge appear on the pins at that same edge.
- R10: In the standard mode and in both direct modes, every pin has its output enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte to store |
| ctrl_out | output | 8 | Stored control byte |
| pwm_carrier | input | 6 | PWM carrier, one bit per pin |
| std_phase | input | 6 | Standard commutation pattern |
| std_pwm_mask | input | 6 | Pins where PWM is applied in standard mode |
| dir_phase | input | 6 | Direct phase-state word |
| dir_pwm_mask | input | 6 | Pins where PWM is applied in direct mode |
| idle_code | input | 12 | Idle code per pin, pin i in bits 2i+1..2i |
| pin_data | output | 6 | Pin data levels |
| pin_oe | output | 6 | Pin output enables |

## Verification
The hardest situation to reach is a freeze in which some pins were carrying PWM and others were static. Which is which depends on the mask and phase seen in the one cycle before timing stops. The stimulus first runs standard mode with a fixed phase and mask, so that some pins carry PWM, one pin is static high and the rest are low. It then clears only the timing-enable bit, once with bit 3 at 0 and once with bit 3 at 1. During the freeze the carrier and phase inputs keep changing, which shows that the frozen pins ignore them.

// File: rtl/motor_gate_pkg.sv
package motor_gate_pkg;

  localparam int unsigned IDLE_W = 2;

  typedef enum logic [1:0] {
    IDLE_Z0 = 2'b00,
    IDLE_LO = 2'b01,
    IDLE_HI = 2'b10,
    IDLE_Z1 = 2'b11
  } idle_e;

  typedef struct packed {
    logic       out_en;
    logic       tim_en;
    logic       sensor;
    logic       direct;
    logic       cur_mode;
    logic [2:0] spare;
  } ctrl_t;

  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_STD,
    MODE_DIR_PWM,
    MODE_DIR_STATIC,
    MODE_FREEZE
  } mode_e;

  function automatic mode_e decode_mode(ctrl_t c);
    if (!c.out_en)      return MODE_IDLE;
    else if (c.direct)  return c.tim_en ? MODE_DIR_PWM : MODE_DIR_STATIC;
    else if (c.tim_en)  return MODE_STD;
    else                return MODE_FREEZE;
  endfunction

endpackage

// File: rtl/motor_rst_sync.sv
module motor_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/motor_ctrl_reg.sv
module motor_ctrl_reg
  import motor_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output ctrl_t      ctrl_o,
  output mode_e      mode_o
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) ctrl_d = ctrl_t'(wr_data_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
  assign mode_o = decode_mode(ctrl_q);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R2: a write lands whole on the following edge
  p_write_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    past_ok && $past(wr_en_i) |-> ctrl_q == $past(wr_data_i));

  // R2: no strobe, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    past_ok && !$past(wr_en_i) |-> $stable(ctrl_q));

endmodule

// File: rtl/motor_pin_sel.sv
module motor_pin_sel
  import motor_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic              cur_mode_i,
  input  logic [IDLE_W-1:0] idle_i,
  input  logic              pwm_i,
  input  logic              std_bit_i,
  input  logic              std_mask_i,
  input  logic              dir_bit_i,
  input  logic              dir_mask_i,
  output logic              dat_o,
  output logic              oe_o
);

  logic  dat_q, dat_d;
  logic  oe_q,  oe_d;
  logic  flg_q, flg_d;
  idle_e idle_code;

  assign idle_code = idle_e'(idle_i);

  always_comb begin
    dat_d = dat_q;
    oe_d  = oe_q;
    flg_d = flg_q;
    unique case (mode_i)
      MODE_IDLE: begin
        oe_d  = (idle_code == IDLE_LO) || (idle_code == IDLE_HI);
        dat_d = (idle_code == IDLE_HI);
        flg_d = 1'b0;
      end
      MODE_STD: begin
        oe_d  = 1'b1;
        dat_d = std_bit_i & (~std_mask_i | pwm_i);
        flg_d = std_bit_i & std_mask_i;
      end
      MODE_DIR_PWM: begin
        oe_d  = 1'b1;
        dat_d = dir_bit_i & (~dir_mask_i | pwm_i);
        flg_d = dir_bit_i & dir_mask_i;
      end
      MODE_DIR_STATIC: begin
        oe_d  = 1'b1;
        dat_d = dir_bit_i;
        flg_d = 1'b0;
      end
      MODE_FREEZE: begin
        if (flg_q) dat_d = ~cur_mode_i;
      end
      default: begin
        oe_d  = 1'b0;
        dat_d = 1'b0;
        flg_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q <= 1'b0;
      oe_q  <= 1'b0;
      flg_q <= 1'b0;
    end else begin
      dat_q <= dat_d;
      oe_q  <= oe_d;
      flg_q <= flg_d;
    end
  end

  assign dat_o = dat_q;
  assign oe_o  = oe_q;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R3: the enable of an idle pin follows its code
  p_idle_oe_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    past_ok && $past(mode_i == MODE_IDLE) |->
      oe_q == ($past(idle_i) == IDLE_LO || $past(idle_i) == IDLE_HI));

  // R7: a static pin keeps its value through a freeze
  p_frz_static_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    past_ok && $past(mode_i == MODE_FREEZE) && !$past(flg_q) |->
      $stable(dat_q) && $stable(oe_q));

  // R8: a pin that carried PWM settles by the mode bit
  p_frz_pwm_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    past_ok && $past(mode_i == MODE_FREEZE) && $past(flg_q) |->
      dat_q == !$past(cur_mode_i));

  // R10: every driving mode enables the pin
  p_drive_oe_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    past_ok && $past(mode_i inside {MODE_STD, MODE_DIR_PWM, MODE_DIR_STATIC}) |-> oe_q);

endmodule

// File: rtl/motor_out_gate.sv
module motor_out_gate
  import motor_gate_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 6,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [7:0]                 wr_data,
  output logic [7:0]                 ctrl_out,
  input  logic [NUM_PINS-1:0]        pwm_carrier,
  input  logic [NUM_PINS-1:0]        std_phase,
  input  logic [NUM_PINS-1:0]        std_pwm_mask,
  input  logic [NUM_PINS-1:0]        dir_phase,
  input  logic [NUM_PINS-1:0]        dir_pwm_mask,
  input  logic [NUM_PINS*IDLE_W-1:0] idle_code,
  output logic [NUM_PINS-1:0]        pin_data,
  output logic [NUM_PINS-1:0]        pin_oe
);

  logic  rst_int_n;
  ctrl_t ctrl;
  mode_e mode;

  motor_rst_sync #(.STAGES(SYNC_DEPTH)) i_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_int_n)
  );

  motor_ctrl_reg i_ctrl_reg (
    .clk       (clk),
    .rst_ni    (rst_int_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .ctrl_o    (ctrl),
    .mode_o    (mode)
  );

  assign ctrl_out = ctrl;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    motor_pin_sel i_pin (
      .clk        (clk),
      .rst_ni     (rst_int_n),
      .mode_i     (mode),
      .cur_mode_i (ctrl.cur_mode),
      .idle_i     (idle_code[p*IDLE_W +: IDLE_W]),
      .pwm_i      (pwm_carrier[p]),
      .std_bit_i  (std_phase[p]),
      .std_mask_i (std_pwm_mask[p]),
      .dir_bit_i  (dir_phase[p]),
      .dir_mask_i (dir_pwm_mask[p]),
      .dat_o      (pin_data[p]),
      .oe_o       (pin_oe[p])
    );
  end

endmodule

// File: tb/test_motor_out_gate.sv
`timescale 1ns/1ps
module test_motor_out_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  ctrl_out;
  logic [5:0]  pwm_carrier = '0, std_phase = '0, std_pwm_mask = '0;
  logic [5:0]  dir_phase = '0, dir_pwm_mask = '0;
  logic [11:0] idle_code = 12'h555;
  logic [5:0]  pin_data, pin_oe;

  always #2.5 clk = ~clk;

  motor_out_gate i_motor_out_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_out(ctrl_out), .pwm_carrier(pwm_carrier), .std_phase(std_phase),
    .std_pwm_mask(std_pwm_mask), .dir_phase(dir_phase),
    .dir_pwm_mask(dir_pwm_mask), .idle_code(idle_code),
    .pin_data(pin_data), .pin_oe(pin_oe)
  );

  int    total = 0;
  int    bad = 0;
  string cur_req = "R1";
  bit    armed = 0;
  bit    done = 0;

  logic [7:0] m_ctrl;
  logic [5:0] m_dat, m_oe, m_flg;

  task automatic expect_val(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model: one update per clock edge
  always @(posedge clk) begin
    if (armed) begin
      logic [5:0] nd, no, nf;
      bit moe, cke, dac, cur;
      moe = m_ctrl[7]; cke = m_ctrl[6]; dac = m_ctrl[4]; cur = m_ctrl[3];
      nd = m_dat; no = m_oe; nf = m_flg;
      for (int i = 0; i < 6; i++) begin
        int code;
        code = idle_code[2*i +: 2];
        if (!moe) begin
          no[i] = (code == 1 || code == 2);
          nd[i] = (code == 2);
          nf[i] = 0;
        end else if (dac && cke) begin
          no[i] = 1;
          nd[i] = dir_pwm_mask[i] ? (dir_phase[i] && pwm_carrier[i]) : dir_phase[i];
          nf[i] = dir_phase[i] && dir_pwm_mask[i];
        end else if (dac) begin
          no[i] = 1; nd[i] = dir_phase[i]; nf[i] = 0;
        end else if (cke) begin
          no[i] = 1;
          nd[i] = std_pwm_mask[i] ? (std_phase[i] && pwm_carrier[i]) : std_phase[i];
          nf[i] = std_phase[i] && std_pwm_mask[i];
        end else if (m_flg[i]) begin
          nd[i] = !cur;
        end
      end
      m_dat <= nd; m_oe <= no; m_flg <= nf;
      if (wr_en) m_ctrl <= wr_data;
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      expect_val({cur_req, " model"}, {ctrl_out, pin_oe, pin_data[5:4]}, {m_ctrl, m_oe, m_dat[5:4]});
      expect_val({cur_req, " model data"}, {10'd0, pin_data}, {10'd0, m_dat});
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rand_in();
    pwm_carrier  = 6'($urandom);
    std_phase    = 6'($urandom);
    std_pwm_mask = 6'($urandom);
    dir_phase    = 6'($urandom);
    dir_pwm_mask = 6'($urandom);
  endtask

  task automatic wr(logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    bad++; total++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    expect_val("R1 reset ctrl", {8'd0, ctrl_out}, 16'h0000);
    expect_val("R1 reset oe", {10'd0, pin_oe}, 16'h0000);
    expect_val("R1 reset data", {10'd0, pin_data}, 16'h0000);
    rst_n = 1'b1;
    cyc(5);
    expect_val("R1 idle after reset", {pin_oe, pin_data}, {6'h3F, 6'h00});
    m_ctrl = 8'h00; m_oe = 6'h3F; m_dat = 6'h00; m_flg = 6'h00;
    armed = 1;

    // R3 idle codes, other bits set
    cur_req = "R3";
    wr(8'h7F);
    expect_val("R2 stored byte", {8'd0, ctrl_out}, 16'h007F);
    idle_code = {2'b10, 2'b01, 2'b00, 2'b10, 2'b01, 2'b11};
    rand_in();
    cyc(1);
    expect_val("R3 idle enables", {10'd0, pin_oe}, 16'h0036);
    expect_val("R3 idle levels", {10'd0, pin_data}, 16'h0024);
    for (int k = 0; k < 10; k++) begin
      idle_code = 12'($urandom); rand_in(); cyc(1);
    end

    // R9 timing of a control change
    cur_req = "R9";
    idle_code = 12'h555;
    std_phase = 6'h3F; std_pwm_mask = 6'h00;
    cyc(2);
    wr(8'hC0);
    expect_val("R9 byte before pins", {ctrl_out, pin_data, 2'b00}, {8'hC0, 6'h00, 2'b00});
    cyc(1);
    expect_val("R9 pins one cycle later", {10'd0, pin_data}, 16'h003F);
    std_phase = 6'h15;
    cyc(1);
    expect_val("R9 input same edge", {10'd0, pin_data}, 16'h0015);

    cur_req = "R4";
    for (int k = 0; k < 25; k++) begin rand_in(); cyc(1); end
    cur_req = "R5";
    wr(8'hD0);
    for (int k = 0; k < 25; k++) begin rand_in(); cyc(1); end
    cur_req = "R6";
    wr(8'h90);
    for (int k = 0; k < 25; k++) begin rand_in(); cyc(1); end
    dir_phase = 6'h2A; dir_pwm_mask = 6'h3F; pwm_carrier = 6'h00;
    cyc(1);
    expect_val("R6 mask ignored", {pin_oe, pin_data}, {6'h3F, 6'h2A});

    // R8 / R7 freeze, voltage mode then current mode
    cur_req = "R8";
    wr(8'hC0);
    std_phase = 6'b111000; std_pwm_mask = 6'b101000;
    for (int k = 0; k < 4; k++) begin pwm_carrier = 6'($urandom); cyc(1); end
    wr(8'h80);
    for (int k = 0; k < 6; k++) begin rand_in(); cyc(1); end
    expect_val("R8 pwm pins high, R7 static hold", {pin_oe, pin_data}, {6'h3F, 6'b111000});
    wr(8'hC8);
    std_phase = 6'b111000; std_pwm_mask = 6'b101000;
    for (int k = 0; k < 4; k++) begin pwm_carrier = 6'($urandom); cyc(1); end
    wr(8'h88);
    for (int k = 0; k < 6; k++) begin rand_in(); cyc(1); end
    expect_val("R8 pwm pins low, R7 static hold", {pin_oe, pin_data}, {6'h3F, 6'b010000});
    cur_req = "R7";
    wr(8'h00);
    idle_code = 12'h0A6;
    cyc(2);
    wr(8'h80);
    for (int k = 0; k < 5; k++) begin rand_in(); idle_code = 12'($urandom); cyc(1); end

    // mixed sequence, R10 enables checked by the model
    cur_req = "R10";
    for (int k = 0; k < 300; k++) begin
      rand_in();
      if (($urandom % 8) == 0) begin
        wr_en = 1'b1; wr_data = 8'($urandom);
      end else begin
        wr_en = 1'b0;
      end
      if (($urandom % 16) == 0) idle_code = 12'($urandom);
      cyc(1);
    end
    wr_en = 1'b0;
    cyc(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule